// File: doc/BRIEF.md
# Wired-AND Processor Bus Source Selector

The block forms the 16-bit processor bus word for each microcycle. A 3-bit source code picks one of the datapath sources: a register-file read, two task-specific inputs, memory data, the mouse bits, or the displacement field of the instruction register. A constant-enable input gates a constant onto the bus in place of the coded source. Any bit that no source drives reads as one. When several sources drive the bus at once, the result is the bitwise AND of all of them. The register-load code forces the bus to zero so that the ALU can pass its other operand while the register file is written, and it raises a register-load request.

For the three upper source codes the constant is always gated on as well, so it acts as a mask over memory data, mouse bits or displacement. The block presents the constant address, made of the register select and the source code, to an external constant store and takes the constant word back on an input port. A control-RAM read issued in one cycle ANDs the RAM data into the bus in the next cycle. The only state in the block is the one-cycle flag for that read. Everything else is combinational.

Top module: `pbus_select`

## Requirements
- R1: With constant-enable low, source code 0 gives the register-file read data on the bus, code 3 gives the first task input and code 4 gives the second task input.
- R2: Source code 1 with constant-enable low drives the bus to 0x0000 and raises reg_load. reg_load is low for every other combination, including code 1 with constant-enable high.
- R3: Source code 2 with constant-enable low and no pending RAM read leaves the bus at 0xFFFF.
- R4: Source code 6 puts the 4 mouse bits on bus bits 3:0 and ones on bits 15:4, before masking.
- R5: Source code 7 with IR[9:8] = 0 puts IR[7:0] on bus bits 7:0 and zeros on bits 15:8, before masking.
- R6: Source code 7 with IR[9:8] nonzero puts IR[7:0] on bus bits 7:0 and copies IR[7] into bits 15:8, before masking.
- R7: With constant-enable high and a source code of 4 or less, the bus equals the constant word and the coded source has no effect.
- R8: For source codes 5, 6 and 7, the bus is the selected source ANDed with the constant word. Code 5 selects memory data. With constant-enable high, the bus is the constant word.
- R9: const_addr equals {rsel, src_sel}, with rsel in bits 7:3 and the source code in bits 2:0.
- R10: When ram_rd_issue was high at the previous rising clock edge, the bus is further ANDed with ram_data for one cycle only.
- R11: Reset (rst_n low, asynchronous) clears the pending RAM-read flag, so the first cycle after reset is not masked by RAM data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Bus source code |
| const_en | input | 1 | Gate the constant in place of the coded source |
| rsel | input | 5 | Register select, upper part of the constant address |
| reg_rdata | input | 16 | Register-file read data |
| task_a | input | 16 | First task-specific source |
| task_b | input | 16 | Second task-specific source |
| md_data | input | 16 | Memory data |
| mouse_bits | input | 4 | Mouse inputs |
| ir | input | 16 | Instruction register |
| const_data | input | 16 | Constant word read at const_addr |
| ram_rd_issue | input | 1 | Control-RAM read issued this cycle |
| ram_data | input | 16 | Control-RAM read data, used in the cycle after the read |
| const_addr | output | 8 | Constant store address |
| bus | output | 16 | Processor bus word |
| reg_load | output | 1 | Register-file load request |

## Verification
The assertions assume that every data input holds a known value and stays steady around each rising edge. They also assume that const_data already reflects the current const_addr within the same cycle. The bench meets these conditions by changing all inputs together on the falling edge. It computes const_data itself from a random draw rather than from a lookup, and it sets const_data to all ones in the directed cases so that the unmasked source can be seen. ram_data and ram_rd_issue are drawn in every cycle. The expected bus is built from a model of the pending flag that the bench keeps from the previous cycle's issue.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   localparam int SRC_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_RREAD  = 3'd0,
      SRC_RLOAD  = 3'd1,
      SRC_NONE   = 3'd2,
      SRC_TASK_A = 3'd3,
      SRC_TASK_B = 3'd4,
      SRC_MEMD   = 3'd5,
      SRC_MOUSE  = 3'd6,
      SRC_DISP   = 3'd7
   } bus_src_e;

   // codes above this one also gate the constant as a mask
   localparam logic [SRC_W-1:0] MASK_ABOVE = 3'd4;
endpackage

// File: rtl/pbus_src_drv.sv
module pbus_src_drv
   import pbus_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MOUSE_W = 4,
   parameter int DISP_W  = 8
) (
   input  logic [SRC_W-1:0]  src_sel,
   input  logic              const_en,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] task_a,
   input  logic [DATA_W-1:0] task_b,
   input  logic [DATA_W-1:0] md_data,
   input  logic [MOUSE_W-1:0] mouse_bits,
   input  logic [DATA_W-1:0] ir,
   output logic              drv_en,
   output logic [DATA_W-1:0] drv_val,
   output logic              reg_load
);
   localparam int EXT_W   = DATA_W - DISP_W;
   localparam int PAD_W   = DATA_W - MOUSE_W;
   localparam int MODE_LO = DISP_W;

   if (DISP_W + 2 > DATA_W) begin : g_bad_disp
      $error("pbus_src_drv: displacement plus mode field wider than bus");
   end
   if (MOUSE_W >= DATA_W) begin : g_bad_mouse
      $error("pbus_src_drv: mouse field must be narrower than bus");
   end

   logic              ext_bit;
   logic [DATA_W-1:0] disp_word;
   logic [DATA_W-1:0] mouse_word;

   assign ext_bit    = (|ir[MODE_LO+1:MODE_LO]) & ir[DISP_W-1];
   assign disp_word  = {{EXT_W{ext_bit}}, ir[DISP_W-1:0]};
   assign mouse_word = {{PAD_W{1'b1}}, mouse_bits};

   always_comb begin
      drv_en   = !const_en;
      drv_val  = '1;
      reg_load = 1'b0;
      unique case (bus_src_e'(src_sel))
         SRC_RREAD:  drv_val = reg_rdata;
         SRC_RLOAD: begin
            drv_val  = '0;
            reg_load = !const_en;
         end
         SRC_NONE:   drv_en  = 1'b0;
         SRC_TASK_A: drv_val = task_a;
         SRC_TASK_B: drv_val = task_b;
         SRC_MEMD:   drv_val = md_data;
         SRC_MOUSE:  drv_val = mouse_word;
         SRC_DISP:   drv_val = disp_word;
         default:    drv_en  = 1'b0;
      endcase
   end
endmodule

// File: rtl/pbus_wand.sv
module pbus_wand #(
   parameter int DATA_W = 16,
   parameter int N_DRV  = 3
) (
   input  logic [N_DRV-1:0]             drv_en,
   input  logic [N_DRV-1:0][DATA_W-1:0] drv_val,
   output logic [DATA_W-1:0]            bus
);
   if (N_DRV < 1) begin : g_bad_n
      $error("pbus_wand: at least one driver required");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic [N_DRV-1:0] pull;
      for (genvar d = 0; d < N_DRV; d++) begin : g_drv
         assign pull[d] = ~drv_en[d] | drv_val[d][b];
      end
      assign bus[b] = &pull;
   end
endmodule

// File: rtl/pbus_ram_flag.sv
module pbus_ram_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic ram_rd_issue,
   output logic ram_pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_pend <= 1'b0;
      else        ram_pend <= ram_rd_issue;
   end
endmodule

// File: rtl/pbus_select.sv
module pbus_select
   import pbus_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MOUSE_W = 4,
   parameter int DISP_W  = 8,
   parameter int RSEL_W  = 5,
   localparam int CADDR_W = RSEL_W + SRC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_W-1:0]   src_sel,
   input  logic               const_en,
   input  logic [RSEL_W-1:0]  rsel,
   input  logic [DATA_W-1:0]  reg_rdata,
   input  logic [DATA_W-1:0]  task_a,
   input  logic [DATA_W-1:0]  task_b,
   input  logic [DATA_W-1:0]  md_data,
   input  logic [MOUSE_W-1:0] mouse_bits,
   input  logic [DATA_W-1:0]  ir,
   input  logic [DATA_W-1:0]  const_data,
   input  logic               ram_rd_issue,
   input  logic [DATA_W-1:0]  ram_data,
   output logic [CADDR_W-1:0] const_addr,
   output logic [DATA_W-1:0]  bus,
   output logic               reg_load
);
   localparam int N_DRV  = 3;
   localparam int D_SRC  = 0;
   localparam int D_CON  = 1;
   localparam int D_RAM  = 2;

   logic                        ram_pend;
   logic                        src_en;
   logic [DATA_W-1:0]           src_val;
   logic [N_DRV-1:0]            drv_en;
   logic [N_DRV-1:0][DATA_W-1:0] drv_val;

   assign const_addr = {rsel, src_sel};

   pbus_src_drv #(
      .DATA_W (DATA_W),
      .MOUSE_W(MOUSE_W),
      .DISP_W (DISP_W)
   ) u_src (
      .src_sel   (src_sel),
      .const_en  (const_en),
      .reg_rdata (reg_rdata),
      .task_a    (task_a),
      .task_b    (task_b),
      .md_data   (md_data),
      .mouse_bits(mouse_bits),
      .ir        (ir),
      .drv_en    (src_en),
      .drv_val   (src_val),
      .reg_load  (reg_load)
   );

   pbus_ram_flag u_ram (
      .clk         (clk),
      .rst_n       (rst_n),
      .ram_rd_issue(ram_rd_issue),
      .ram_pend    (ram_pend)
   );

   assign drv_en[D_SRC]  = src_en;
   assign drv_val[D_SRC] = src_val;
   assign drv_en[D_CON]  = const_en | (src_sel > MASK_ABOVE);
   assign drv_val[D_CON] = const_data;
   assign drv_en[D_RAM]  = ram_pend;
   assign drv_val[D_RAM] = ram_data;

   pbus_wand #(
      .DATA_W(DATA_W),
      .N_DRV (N_DRV)
   ) u_wand (
      .drv_en (drv_en),
      .drv_val(drv_val),
      .bus    (bus)
   );
endmodule

// File: rtl/pbus_select_chk.sv
module pbus_select_chk
   import pbus_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MOUSE_W = 4,
   parameter int DISP_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [SRC_W-1:0]   src_sel,
   input logic               const_en,
   input logic [MOUSE_W-1:0] mouse_bits,
   input logic [DATA_W-1:0]  ir,
   input logic [DATA_W-1:0]  const_data,
   input logic               ram_rd_issue,
   input logic [DATA_W-1:0]  ram_data,
   input logic [DATA_W-1:0]  bus,
   input logic               reg_load,
   input logic               ram_pend
);
   localparam int EXT_W = DATA_W - DISP_W;

   // R2
   load_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_load |-> (bus == '0));

   // R2
   load_only_on_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_load |-> (src_sel == SRC_RLOAD && !const_en));

   // R3
   idle_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_NONE && !const_en && !ram_pend) |-> (bus == '1));

   // R4
   mouse_low_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_MOUSE && !const_en) |-> ((bus[MOUSE_W-1:0] & ~mouse_bits) == '0));

   // R5
   disp_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_DISP && !const_en && ir[DISP_W+1:DISP_W] == 2'b00)
      |-> (bus[DATA_W-1:DISP_W] == '0));

   // R7
   const_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (const_en && src_sel <= MASK_ABOVE && !ram_pend) |-> (bus == const_data));

   // R8
   const_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel > MASK_ABOVE) |-> ((bus & ~const_data) == '0));

   // R10
   ram_flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_issue |=> ram_pend);

   // R10
   ram_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_pend |-> ((bus & ~ram_data) == '0));

   wire unused_ok = ^{EXT_W};
endmodule

bind pbus_select pbus_select_chk #(
   .DATA_W (DATA_W),
   .MOUSE_W(MOUSE_W),
   .DISP_W (DISP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_sel     (src_sel),
   .const_en    (const_en),
   .mouse_bits  (mouse_bits),
   .ir          (ir),
   .const_data  (const_data),
   .ram_rd_issue(ram_rd_issue),
   .ram_data    (ram_data),
   .bus         (bus),
   .reg_load    (reg_load),
   .ram_pend    (ram_pend)
);

// File: tb/tb_pbus_select.sv
module tb_pbus_select;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  src_sel = 3'd2;
   logic        const_en = 1'b0;
   logic [4:0]  rsel = '0;
   logic [15:0] reg_rdata = '0, task_a = '0, task_b = '0, md_data = '0;
   logic [3:0]  mouse_bits = '0;
   logic [15:0] ir = '0, const_data = 16'hFFFF, ram_data = '0;
   logic        ram_rd_issue = 1'b1;
   logic [7:0]  const_addr;
   logic [15:0] bus;
   logic        reg_load;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   bit  pend_m = 0;

   always #(PERIOD/2) clk = ~clk;

   pbus_select dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .const_en(const_en),
      .rsel(rsel), .reg_rdata(reg_rdata), .task_a(task_a), .task_b(task_b),
      .md_data(md_data), .mouse_bits(mouse_bits), .ir(ir),
      .const_data(const_data), .ram_rd_issue(ram_rd_issue), .ram_data(ram_data),
      .const_addr(const_addr), .bus(bus), .reg_load(reg_load)
   );

   function automatic logic [15:0] exp_bus(input logic [2:0] s, input logic ce,
                                           input logic pend);
      logic [15:0] v;
      if (ce) v = const_data;
      else begin
         case (s)
            3'd0: v = reg_rdata;
            3'd1: v = 16'h0000;
            3'd2: v = 16'hFFFF;
            3'd3: v = task_a;
            3'd4: v = task_b;
            3'd5: v = md_data;
            3'd6: v = {12'hFFF, mouse_bits};
            default: v = {{8{(|ir[9:8]) & ir[7]}}, ir[7:0]};
         endcase
      end
      if (s > 3'd4) v = v & const_data;
      if (pend) v = v & ram_data;
      return v;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply inputs at falling edge, check, then track the pending flag
   task automatic step(input string tag);
      string t;
      #1;
      t = tag;
      if (t == "") begin
         if (pend_m)              t = "R10";
         else if (const_en)       t = "R7";
         else if (src_sel > 3'd4) t = "R8";
         else if (src_sel == 3'd1) t = "R2";
         else if (src_sel == 3'd2) t = "R3";
         else                     t = "R1";
      end
      chk(t, bus, exp_bus(src_sel, const_en, pend_m));
      chk("R2 reg_load", {15'b0, reg_load}, {15'b0, (src_sel == 3'd1) && !const_en});
      chk("R9 const_addr", {8'b0, const_addr}, {8'b0, rsel, src_sel});
      @(posedge clk);
      #1 pend_m = rst_n ? ram_rd_issue : 1'b0;
      @(negedge clk);
   endtask

   task automatic setsrc(input logic [2:0] s, input logic ce, input logic [15:0] cd);
      src_sel = s; const_en = ce; const_data = cd; ram_rd_issue = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      reg_rdata = 16'h1357; task_a = 16'hA5C3; task_b = 16'h0F0F;
      md_data = 16'h8421; mouse_bits = 4'b1010; ram_data = 16'h00FF;
      @(negedge clk);
      // R11: reset holds flag clear even with issue high
      step("R11 in reset");
      step("R11 in reset");
      rst_n = 1'b1; ram_rd_issue = 1'b0;
      step("R11 after reset");
      // R1
      setsrc(3'd0, 0, 16'hFFFF); step("R1 reg read");
      setsrc(3'd3, 0, 16'hFFFF); step("R1 task a");
      setsrc(3'd4, 0, 16'hFFFF); step("R1 task b");
      // R2 / R3
      setsrc(3'd1, 0, 16'hFFFF); step("R2 load");
      setsrc(3'd1, 1, 16'h3C3C); step("R2 load with const");
      setsrc(3'd2, 0, 16'h0000); step("R3 none");
      // R4
      setsrc(3'd6, 0, 16'hFFFF); step("R4 mouse");
      mouse_bits = 4'b0101; step("R4 mouse");
      // R5 / R6
      setsrc(3'd7, 0, 16'hFFFF);
      ir = 16'h0C80 & 16'hFCFF | 16'h0080; step("R5 disp zero ext");
      ir = 16'h01A5; step("R6 disp sign ext");
      ir = 16'h0293; step("R6 disp sign ext");
      ir = 16'h0345; step("R6 disp positive");
      // R7 / R8
      setsrc(3'd0, 1, 16'hBEEF); step("R7 const replaces");
      setsrc(3'd4, 1, 16'h1234); step("R7 const replaces");
      setsrc(3'd5, 0, 16'hF0F0); step("R8 md mask");
      setsrc(3'd7, 0, 16'h0F0F); ir = 16'h01FF; step("R8 disp mask");
      setsrc(3'd6, 1, 16'h5A5A); step("R8 const on");
      // R10
      setsrc(3'd2, 0, 16'hFFFF); ram_rd_issue = 1'b1; step("R10 issue");
      ram_rd_issue = 1'b0; ram_data = 16'h0FF0; step("R10 masked");
      step("R10 one cycle only");
      // random
      for (int i = 0; i < 400; i++) begin
         src_sel      = 3'($urandom);
         const_en     = ($urandom % 4) == 0;
         rsel         = 5'($urandom);
         reg_rdata    = 16'($urandom);
         task_a       = 16'($urandom);
         task_b       = 16'($urandom);
         md_data      = 16'($urandom);
         mouse_bits   = 4'($urandom);
         ir           = 16'($urandom);
         const_data   = (($urandom % 3) == 0) ? 16'hFFFF : 16'($urandom);
         ram_data     = 16'($urandom) | 16'($urandom);
         ram_rd_issue = ($urandom % 3) == 0;
         step("");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule